// File: doc/BRIEF.md
# PWM Channel with Dithered Duty and Fade

This block drives one pulse-width-modulated output from an external timebase. A two-bit selector chooses one of four timer counts, each with its own wrap pulse. The output rises when the chosen count matches a programmed rise point. It falls when the count matches a fall point. The fall point is the rise point plus the integer part of the duty value, with one more count added in some periods.

The duty value is 25 bits wide, and its lowest four bits are sixteenths of a count. A four-bit phase counter advances on every wrap of the chosen timer. Its bit-reversed value is compared with the fraction to decide which periods get the extra count. Over sixteen periods the fraction is therefore spread as evenly as possible.

A fade sequencer moves the duty in steps. It adds or subtracts a step amount once every N periods, for a programmed number of steps, and clamps at both ends of the range. It reports completion with a one-cycle pulse. The start strobe is a single-cycle control pulse. It loads the duty and all fade settings. A start with a step count of zero simply sets a static duty. All pins are plain control and status signals, and there is no streaming interface.

Top module: `pwm_dither_fade`

## Requirements
- R1: `tmr_sel_i` picks the timebase: value k (00 through 11) selects count slice k of `tmr_cnt_i` (bits 20k+19..20k) and wrap bit k of `tmr_wrap_i`, so the output repeats at the selected timer's period.
- R2: The internal PWM level becomes 1 in the clock cycle after the selected count equals `hpoint_i`.
- R3: The level becomes 0 in the clock cycle after the count equals the fall point, which is `hpoint_i + duty[24:4] + e` modulo 2^20 with e equal to 0 or 1. When both points match at once, low wins, so a duty of 0 never produces a pulse.
- R4: The phase counter advances only on a selected wrap. Over any 16 consecutive periods, e is 1 in exactly duty[3:0] of them, so the total high time is 16*duty[24:4] + duty[3:0] cycles. A fraction of 0 gives every period the same width.
- R5: While `out_en_i` is 0, `pwm_o` equals `idle_lvl_i`. While it is 1, `pwm_o` follows the PWM level.
- R6: A one-cycle `start_i` loads `duty_i` and the fade settings. `duty_o` shows the loaded value in the next cycle. The duty does not change while no fade is running, and a start during a fade restarts it.
- R7: During a fade, each group of `fade_intv_i` selected wraps (a value of 0 counts as 1) changes the raw 25-bit duty by `fade_step_i`. The change is upward when `fade_up_i` is 1 and downward when it is 0, and it repeats `fade_num_i` times.
- R8: Fade arithmetic clamps at 0 and at 2^25-1 instead of wrapping.
- R9: `fade_done_o` is a one-cycle pulse that appears in the same cycle as the final duty. A start with `fade_num_i` = 0 pulses it in the cycle after the start.
- R10: After reset, the PWM level, `duty_o` and `fade_done_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tmr_cnt_i | input | 80 | Four 20-bit timer counts, timer k in bits 20k+19..20k |
| tmr_wrap_i | input | 4 | Wrap pulse of each timer, high while its count is at the start of a period |
| tmr_sel_i | input | 2 | Timer select |
| hpoint_i | input | 20 | Rise point |
| duty_i | input | 25 | Duty loaded on start, 4 fractional bits |
| fade_step_i | input | 10 | Duty change per fade step, in raw LSBs |
| fade_intv_i | input | 10 | Periods between fade steps |
| fade_num_i | input | 10 | Number of fade steps |
| fade_up_i | input | 1 | Fade direction, 1 = increase |
| start_i | input | 1 | Single-cycle load and start strobe |
| out_en_i | input | 1 | Output enable |
| idle_lvl_i | input | 1 | Output level while disabled |
| pwm_o | output | 1 | PWM output |
| duty_o | output | 25 | Current duty |
| fade_done_o | output | 1 | Fade completion pulse |

## Verification
The bench adds up the high time over sixteen whole periods for several fractions. An error in the phase spreading, or a comparison made on the wrong phase, would move that total away from sixteen times the integer part plus the fraction. It measures where the output rises and falls relative to the count, and it drives a zero duty, which a design without low-wins priority would turn into a full-period pulse. Fades are run near both range limits, where unclamped arithmetic would wrap to a huge or tiny duty. The bench counts the wraps that elapse before the done pulse, so an off-by-one in the interval counter shows up as an extra or missing period. A zero-step start must complete at once rather than run 1024 steps.

// File: rtl/pwm_dither_pkg.sv
`timescale 1ns/1ps
package pwm_dither_pkg;
  localparam int CNT_W  = 20;
  localparam int DUTY_W = 25;
  localparam int FRAC_W = 4;
  localparam int FADE_W = 10;
  localparam int N_TMR  = 4;

  typedef enum logic {FADE_IDLE, FADE_RUN} fade_st_e;

  typedef struct packed {
    logic [FADE_W-1:0] step;
    logic [FADE_W-1:0] intv;
    logic              up;
  } fade_cfg_t;
endpackage

// File: rtl/pwm_tsel.sv
`timescale 1ns/1ps
module pwm_tsel #(
  parameter int NT = 4,
  parameter int CW = 20,
  localparam int SW = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic [NT*CW-1:0] cnt_bus_i,
  input  logic [NT-1:0]    wrap_bus_i,
  input  logic [SW-1:0]    sel_i,
  output logic [CW-1:0]    cnt_o,
  output logic             wrap_o
);
  always_comb begin
    cnt_o  = '0;
    wrap_o = 1'b0;
    for (int k = 0; k < NT; k++) begin
      if (sel_i == SW'(k)) begin
        cnt_o  = cnt_bus_i[k*CW +: CW];
        wrap_o = wrap_bus_i[k];
      end
    end
  end
endmodule

// File: rtl/pwm_dither.sv
`timescale 1ns/1ps
module pwm_dither #(
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wrap_i,
  input  logic [FW-1:0] frac_i,
  output logic          extra_o
);
  logic [FW-1:0] phase_q;
  logic [FW-1:0] phase_rev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      phase_q <= '0;
    else if (wrap_i) phase_q <= phase_q + 1'b1;
  end

  // bit reversal spreads the long periods evenly over the 2^FW cycle
  always_comb begin
    for (int i = 0; i < FW; i++) phase_rev[i] = phase_q[FW-1-i];
  end

  assign extra_o = (phase_rev < frac_i);

  // R4: phase moves only on a selected wrap
  a_r4_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_i |=> $stable(phase_q));
endmodule

// File: rtl/pwm_fade.sv
`timescale 1ns/1ps
module pwm_fade
  import pwm_dither_pkg::*;
#(
  parameter int DW  = 25,
  parameter int FDW = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [DW-1:0]  duty_i,
  input  logic [FDW-1:0] step_i,
  input  logic [FDW-1:0] intv_i,
  input  logic [FDW-1:0] num_i,
  input  logic           up_i,
  input  logic           wrap_i,
  output logic [DW-1:0]  duty_o,
  output logic           done_o
);
  localparam logic [DW-1:0] DUTY_MAX = {DW{1'b1}};

  fade_st_e        st_q;
  logic [DW-1:0]   duty_q;
  logic            done_q;
  logic [FDW-1:0]  ivl_q;
  logic [FDW-1:0]  left_q;
  logic [FDW-1:0]  step_q;
  logic [FDW-1:0]  intv_q;
  logic            up_q;
  logic [FDW-1:0]  ivl_last;
  logic [DW:0]     sum;
  logic [DW-1:0]   stepped;

  assign ivl_last = (intv_q == '0) ? '0 : intv_q - 1'b1;
  assign sum      = {1'b0, duty_q} + (DW+1)'(step_q);

  always_comb begin
    if (up_q)                        stepped = sum[DW] ? DUTY_MAX : sum[DW-1:0];
    else if (duty_q < DW'(step_q))   stepped = '0;
    else                             stepped = duty_q - DW'(step_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FADE_IDLE;
      duty_q <= '0;
      done_q <= 1'b0;
      ivl_q  <= '0;
      left_q <= '0;
      step_q <= '0;
      intv_q <= '0;
      up_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        duty_q <= duty_i;
        step_q <= step_i;
        intv_q <= intv_i;
        up_q   <= up_i;
        ivl_q  <= '0;
        left_q <= num_i;
        if (num_i == '0) begin
          st_q   <= FADE_IDLE;
          done_q <= 1'b1;
        end else begin
          st_q   <= FADE_RUN;
        end
      end else if (st_q == FADE_RUN && wrap_i) begin
        if (ivl_q >= ivl_last) begin
          ivl_q  <= '0;
          duty_q <= stepped;
          left_q <= left_q - 1'b1;
          if (left_q == FDW'(1)) begin
            st_q   <= FADE_IDLE;
            done_q <= 1'b1;
          end
        end else begin
          ivl_q <= ivl_q + 1'b1;
        end
      end
    end
  end

  assign duty_o = duty_q;
  assign done_o = done_q;

  // R9: completion is a single-cycle pulse
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R6: duty is held while no fade runs and no start arrives
  a_r6_duty_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FADE_IDLE && !start_i) |=> $stable(duty_q));
endmodule

// File: rtl/pwm_edge.sv
`timescale 1ns/1ps
module pwm_edge #(
  parameter int CW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] hp_i,
  input  logic [CW-1:0] lp_i,
  output logic          lvl_o
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              lvl_q <= 1'b0;
    else if (cnt_i == lp_i)  lvl_q <= 1'b0;
    else if (cnt_i == hp_i)  lvl_q <= 1'b1;
  end

  assign lvl_o = lvl_q;

  // R2: a rising level follows a match on the rise point
  a_r2_rise_at_hp: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lvl_q) |-> $past(cnt_i) == $past(hp_i));
  // R3: a falling level follows a match on the fall point
  a_r3_fall_at_lp: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lvl_q) |-> $past(cnt_i) == $past(lp_i));
endmodule

// File: rtl/pwm_dither_fade.sv
`timescale 1ns/1ps
module pwm_dither_fade
  import pwm_dither_pkg::*;
#(
  parameter int NT  = N_TMR,
  parameter int CW  = CNT_W,
  parameter int DW  = DUTY_W,
  parameter int FW  = FRAC_W,
  parameter int FDW = FADE_W,
  localparam int SW = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NT*CW-1:0] tmr_cnt_i,
  input  logic [NT-1:0]  tmr_wrap_i,
  input  logic [SW-1:0]  tmr_sel_i,
  input  logic [CW-1:0]  hpoint_i,
  input  logic [DW-1:0]  duty_i,
  input  logic [FDW-1:0] fade_step_i,
  input  logic [FDW-1:0] fade_intv_i,
  input  logic [FDW-1:0] fade_num_i,
  input  logic           fade_up_i,
  input  logic           start_i,
  input  logic           out_en_i,
  input  logic           idle_lvl_i,
  output logic           pwm_o,
  output logic [DW-1:0]  duty_o,
  output logic           fade_done_o
);
  logic [CW-1:0] cnt_sel;
  logic          wrap_sel;
  logic          extra;
  logic [DW-1:0] duty_cur;
  logic [CW-1:0] lpoint;
  logic          lvl;

  pwm_tsel #(.NT(NT), .CW(CW)) u_tsel (
    .cnt_bus_i (tmr_cnt_i),
    .wrap_bus_i(tmr_wrap_i),
    .sel_i     (tmr_sel_i),
    .cnt_o     (cnt_sel),
    .wrap_o    (wrap_sel)
  );

  pwm_fade #(.DW(DW), .FDW(FDW)) u_fade (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_i),
    .duty_i (duty_i),
    .step_i (fade_step_i),
    .intv_i (fade_intv_i),
    .num_i  (fade_num_i),
    .up_i   (fade_up_i),
    .wrap_i (wrap_sel),
    .duty_o (duty_cur),
    .done_o (fade_done_o)
  );

  pwm_dither #(.FW(FW)) u_dither (
    .clk    (clk),
    .rst_n  (rst_n),
    .wrap_i (wrap_sel),
    .frac_i (duty_cur[FW-1:0]),
    .extra_o(extra)
  );

  assign lpoint = hpoint_i + duty_cur[FW +: CW] + CW'(extra);

  pwm_edge #(.CW(CW)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .cnt_i(cnt_sel),
    .hp_i (hpoint_i),
    .lp_i (lpoint),
    .lvl_o(lvl)
  );

  assign pwm_o  = out_en_i ? lvl : idle_lvl_i;
  assign duty_o = duty_cur;
endmodule

// File: tb/tb_pwm_dither_fade.sv
`timescale 1ns/1ps
module tb_pwm_dither_fade;
  localparam int CW = 20;
  localparam int DW = 25;
  localparam int PER [4] = '{64, 96, 48, 80};
  localparam logic [DW-1:0] DMAX = {DW{1'b1}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CW-1:0] tc [4];
  logic [4*CW-1:0] tmr_cnt;
  logic [3:0] tmr_wrap;
  logic [1:0] sel = 2'd0;
  logic [CW-1:0] hp = 20'd4;
  logic [DW-1:0] duty_in = '0;
  logic [9:0] f_step = '0, f_intv = '0, f_num = '0;
  logic f_up = 1'b0, start = 1'b0, out_en = 1'b1, idle = 1'b0;
  logic pwm;
  logic [DW-1:0] duty_out;
  logic done;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n) begin
    for (int k = 0; k < 4; k++) begin
      if (!rst_n) tc[k] <= '0;
      else        tc[k] <= (tc[k] == CW'(PER[k]-1)) ? '0 : tc[k] + 1'b1;
    end
  end

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      tmr_cnt[k*CW +: CW] = tc[k];
      tmr_wrap[k] = (tc[k] == '0);
    end
  end

  pwm_dither_fade dut (
    .clk(clk), .rst_n(rst_n), .tmr_cnt_i(tmr_cnt), .tmr_wrap_i(tmr_wrap),
    .tmr_sel_i(sel), .hpoint_i(hp), .duty_i(duty_in), .fade_step_i(f_step),
    .fade_intv_i(f_intv), .fade_num_i(f_num), .fade_up_i(f_up), .start_i(start),
    .out_en_i(out_en), .idle_lvl_i(idle), .pwm_o(pwm), .duty_o(duty_out),
    .fade_done_o(done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic set_duty(input logic [DW-1:0] d);
    duty_in = d; f_num = '0;
    pulse_start();
  endtask

  task automatic wait_wrap();
    do @(negedge clk); while (!tmr_wrap[sel]);
  endtask

  task automatic high_time(input int nper, output int total);
    wait_wrap();
    total = 0;
    repeat (nper * PER[sel]) begin
      @(negedge clk);
      total += int'(pwm);
    end
  endtask

  task automatic t_reset();
    chk(pwm == 1'b0, "R10 pwm", pwm, 0);
    chk(duty_out == '0, "R10 duty", duty_out, 0);
    chk(done == 1'b0, "R10 done", done, 0);
  endtask

  task automatic t_load();
    set_duty({21'd10, 4'd0});
    chk(duty_out == {21'd10, 4'd0}, "R6 load", duty_out, 160);
    chk(done == 1'b1, "R9 zero-step done", done, 1);
    @(negedge clk);
    chk(done == 1'b0, "R9 done single", done, 0);
  endtask

  task automatic t_edges();
    logic [CW-1:0] prev_vis;
    logic prev_pwm;
    int rise_at, fall_at, w;
    rise_at = -1; fall_at = -1;
    wait_wrap();
    prev_vis = tc[sel]; prev_pwm = pwm;
    repeat (PER[sel]) begin
      @(negedge clk);
      if (!prev_pwm && pwm) rise_at = int'(prev_vis);
      if (prev_pwm && !pwm) fall_at = int'(prev_vis);
      prev_vis = tc[sel]; prev_pwm = pwm;
    end
    chk(rise_at == 4, "R2 rise count", rise_at, 4);
    chk(fall_at == 14, "R3 fall count", fall_at, 14);
    for (int p = 0; p < 3; p++) begin
      high_time(1, w);
      chk(w == 10, "R4 frac zero per period", w, 10);
    end
  endtask

  task automatic t_dither(input int ip, input int fr);
    int tot;
    set_duty(DW'(ip * 16 + fr));
    high_time(16, tot);
    chk(tot == 16 * ip + fr, "R4 sixteen-period total", tot, 16 * ip + fr);
  endtask

  task automatic t_zero();
    int tot;
    set_duty('0);
    high_time(2, tot);
    chk(tot == 0, "R3 zero duty no pulse", tot, 0);
  endtask

  task automatic t_idle();
    int tot;
    set_duty({21'd10, 4'd0});
    out_en = 1'b0; idle = 1'b1;
    high_time(1, tot);
    chk(tot == PER[sel], "R5 idle high", tot, PER[sel]);
    idle = 1'b0;
    high_time(1, tot);
    chk(tot == 0, "R5 idle low", tot, 0);
    out_en = 1'b1;
  endtask

  task automatic t_select(input logic [1:0] s);
    int n, first, second;
    logic prev_pwm;
    sel = s;
    set_duty({21'd10, 4'd0});
    first = -1; second = -1; n = 0;
    prev_pwm = pwm;
    while (second < 0 && n < 400) begin
      @(negedge clk); n++;
      if (!prev_pwm && pwm) begin
        if (first < 0) first = n; else second = n;
      end
      prev_pwm = pwm;
    end
    chk(second - first == PER[s], "R1 period of selected timer", second - first, PER[s]);
  endtask

  task automatic t_fade(input logic [DW-1:0] d0, input int step, input int intv,
                        input int num, input bit up, input string req);
    logic [DW-1:0] exp_d, last_d;
    longint t;
    int wraps, changes, n, exp_changes;
    exp_d = d0; exp_changes = 0;
    for (int i = 0; i < num; i++) begin
      t = up ? longint'(exp_d) + step : longint'(exp_d) - step;
      if (t < 0) t = 0;
      if (t > longint'(DMAX)) t = longint'(DMAX);
      if (DW'(t) != exp_d) exp_changes++;
      exp_d = DW'(t);
    end
    duty_in = d0; f_step = 10'(step); f_intv = 10'(intv); f_num = 10'(num); f_up = up;
    pulse_start();
    chk(duty_out == d0, {req, " start value"}, duty_out, d0);
    wraps = 0; changes = 0; n = 0; last_d = duty_out;
    while (!done && n < 20000) begin
      if (tmr_wrap[sel]) wraps++;
      @(negedge clk); n++;
      if (duty_out != last_d) changes++;
      last_d = duty_out;
    end
    chk(done == 1'b1, {req, " done seen"}, done, 1);
    chk(duty_out == exp_d, {req, " final duty"}, duty_out, exp_d);
    chk(wraps == (intv == 0 ? 1 : intv) * num, {req, " wraps to finish"}, wraps,
        (intv == 0 ? 1 : intv) * num);
    chk(changes == exp_changes, {req, " step count"}, changes, exp_changes);
    @(negedge clk);
    chk(done == 1'b0, "R9 done single", done, 0);
    repeat (2 * PER[sel]) @(negedge clk);
    chk(duty_out == exp_d, "R6 duty held after fade", duty_out, exp_d);
  endtask

  task automatic t_restart();
    duty_in = 25'd1000; f_step = 10'd50; f_intv = 10'd1; f_num = 10'd20; f_up = 1'b1;
    pulse_start();
    wait_wrap(); wait_wrap(); @(negedge clk);
    duty_in = 25'd300; f_num = 10'd0;
    pulse_start();
    chk(duty_out == 25'd300, "R6 restart reload", duty_out, 300);
    repeat (3 * PER[sel]) @(negedge clk);
    chk(duty_out == 25'd300, "R6 restart stops old fade", duty_out, 300);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_load();
    t_edges();
    t_dither(10, 5);
    t_dither(12, 8);
    t_dither(6, 15);
    t_zero();
    t_idle();
    t_select(2'd2);
    t_select(2'd1);
    t_select(2'd3);
    sel = 2'd0;
    t_fade(25'd200, 16, 3, 4, 1'b1, "R7 fade up");
    t_fade(25'd500, 30, 0, 3, 1'b0, "R7 fade down interval zero");
    t_fade(25'd20, 8, 1, 5, 1'b0, "R8 clamp low");
    t_fade(DMAX - 25'd10, 8, 2, 3, 1'b1, "R8 clamp high");
    t_restart();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule